// File: doc/BRIEF.md
# Dual Alarm Match Interrupt Unit

This block holds two alarm settings and compares each against the calendar clock fields supplied by an external time counter: seconds, minutes, hours, date, month and day of week. In every alarm byte, bit 7 enables the compare for that field and bits 6:0 hold the BCD value. An alarm matches when all of its enabled fields equal the clock. Compares happen only on the one-second update strobe `tick`. The match is edge detected, so one match window gives one event.

Both alarms drive one active-low interrupt line. In latched mode an event sets that alarm's status flag, and `irq_n` stays low until both flags are cleared. Software clears a flag by writing 0 to its status bit. If auto-clear is enabled, a status read clears both flags. In pulsed mode, every event from either alarm drives `irq_n` low for a fixed number of clock cycles.

The register map is: 0 = control, 1 = status, 2..7 = alarm 0 fields, 8..13 = alarm 1 fields. Within each alarm the field order is seconds, minutes, hours, date, month, day of week. Control bits are: bit 0 enables alarm 0, bit 1 enables alarm 1, bit 2 selects pulsed mode, bit 3 enables auto-clear. Bits 7:4 of control read as 0. Status bit 0 is flag 0 and status bit 1 is flag 1.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset, control, status and all alarm bytes read 0 and `irq_n` is 1.
- R2: On a `tick` cycle, alarm k matches when its control enable is 1, at least one of its bytes has bit 7 set, and every byte with bit 7 set has bits 6:0 equal to bits 6:0 of the matching clock field. Bytes with bit 7 clear do not affect the result.
- R3: An alarm whose six bytes all have bit 7 clear never produces an event, whatever the clock fields are.
- R4: An event occurs only on a `tick` where the alarm matches and did not match on the previous `tick`. Repeated matching ticks give no further events.
- R5: In latched mode (control bit 2 = 0), an event sets its status flag at the clock edge that samples `tick`. `irq_n` goes low at that edge and stays low while either flag is 1.
- R6: Writing status clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R7: With control bit 3 = 1, a cycle with `rd_strobe` = 1 and `rd_addr` = 1 returns the current flags on `rd_data` and clears both flags at the next edge. With bit 3 = 0, such a read changes nothing.
- R8: In pulsed mode (control bit 2 = 1), each event of either alarm drives `irq_n` low for exactly PULSE_W clock cycles starting at the edge that samples `tick`. The flag is still set.
- R9: With an alarm's control enable at 0, a match of its bytes sets no flag and leaves `irq_n` high.
- R10: A write to any mapped address is returned on `rd_data` from the next cycle. Control bits 7:4 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address (read data is combinational) |
| rd_strobe | input | 1 | Marks a completed read of `rd_addr` |
| rd_data | output | 8 | Read data |
| tick | input | 1 | One-cycle strobe when the clock fields have updated |
| t_sec | input | 8 | Clock seconds, BCD |
| t_min | input | 8 | Clock minutes, BCD |
| t_hour | input | 8 | Clock hours, BCD |
| t_date | input | 8 | Clock date, BCD |
| t_month | input | 8 | Clock month, BCD |
| t_dow | input | 8 | Clock day of week, 0 to 6 |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
Read data is combinational, so the bench checks it 1 ns after changing `rd_addr`. Register writes become visible one cycle after the write strobe. Flags and `irq_n` update at the same rising edge that samples `tick`, so the bench raises `tick` at a falling edge and checks status and `irq_n` at the next falling edge. In pulsed mode the bench counts the falling edges at which `irq_n` is low, starting from that point, and expects exactly PULSE_W of them. An auto-clear read is checked twice: first on `rd_data` during the strobe cycle, then one cycle later when the flags are 0.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_ALARMS = 2;
  localparam int NUM_FIELDS = 6;
  localparam int BYTE_W     = 8;

  // register map
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_STAT     = 1;
  localparam int ADDR_ALM_BASE = 2;
  localparam int ADDR_LAST     = ADDR_ALM_BASE + NUM_ALARMS * NUM_FIELDS - 1;

  // control bit positions
  localparam int CTL_EN0  = 0;
  localparam int CTL_MODE = 2;
  localparam int CTL_AUTO = 3;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h0F;

  typedef logic [BYTE_W-1:0] byte_t;

  // one field passes if its compare is disabled or its BCD value equals the clock
  function automatic logic field_pass(byte_t alm, byte_t clk_field);
    return !alm[BYTE_W-1] || (alm[BYTE_W-2:0] == clk_field[BYTE_W-2:0]);
  endfunction

  function automatic int field_addr(int alarm, int field);
    return ADDR_ALM_BASE + alarm * NUM_FIELDS + field;
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      wr_en,
  input  logic [ADDR_W-1:0]                         wr_addr,
  input  logic [BYTE_W-1:0]                         wr_data,
  input  logic [ADDR_W-1:0]                         rd_addr,
  input  logic [NUM_ALARMS-1:0]                     flags_i,
  output logic [BYTE_W-1:0]                         ctrl_o,
  output logic [NUM_ALARMS-1:0][NUM_FIELDS-1:0][BYTE_W-1:0] alm_o,
  output logic [NUM_ALARMS-1:0]                     clr_mask_o,
  output logic [BYTE_W-1:0]                         rd_data_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic [BYTE_W-1:0] ctrl_q;
  logic              wr_ctrl;
  logic              wr_stat;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data & CTRL_MASK;
  end
  assign ctrl_o = ctrl_q;

  // zero bits in a status write clear the matching flag
  assign clr_mask_o = wr_stat ? ~wr_data[NUM_ALARMS-1:0] : '0;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(field_addr(a, f));
      byte_t fld_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             fld_q <= '0;
        else if (wr_en && wr_addr == MY_ADDR)   fld_q <= wr_data;
      end
      assign alm_o[a][f] = fld_q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr == A_CTRL) rd_data_o = ctrl_q;
    if (rd_addr == A_STAT) rd_data_o = BYTE_W'(flags_i);
    for (int a = 0; a < NUM_ALARMS; a++) begin
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (rd_addr == ADDR_W'(field_addr(a, f))) rd_data_o = alm_o[a][f];
      end
    end
  end

  assert_ctrl_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_o == ($past(wr_data) & CTRL_MASK)));
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  logic                                enable,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0]   alm_i,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0]   time_i,
  output logic                                match_o,
  output logic                                hit_o
);
  logic [NUM_FIELDS-1:0] pass_vec;
  logic [NUM_FIELDS-1:0] en_vec;
  logic                  any_en;
  logic                  prev_q;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    assign pass_vec[f] = field_pass(alm_i[f], time_i[f]);
    assign en_vec[f]   = alm_i[f][BYTE_W-1];
  end

  assign any_en  = |en_vec;
  assign match_o = enable && any_en && (&pass_vec);

  // match state as seen at the previous tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= 1'b0;
    else if (tick) prev_q <= match_o;
  end

  assign hit_o = tick && match_o && !prev_q;

  assert_no_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_en) |-> !hit_o);
  assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !hit_o);
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen
  import alarm_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] hit_i,
  input  logic                  pulse_mode,
  input  logic [NUM_ALARMS-1:0] clr_mask_i,
  input  logic                  auto_clr_i,
  output logic [NUM_ALARMS-1:0] flags_o,
  output logic                  irq_n_o
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic [NUM_ALARMS-1:0] flags_q;
  logic [CW-1:0]         cnt_q;
  logic                  any_hit;

  assign any_hit = |hit_i;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask_i & {NUM_ALARMS{!auto_clr_i}}) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (pulse_mode && any_hit)  cnt_q <= CW'(PULSE_W);
    else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
  end

  assign flags_o = flags_q;
  assign irq_n_o = pulse_mode ? (cnt_q == '0) : !(|flags_q);

  assert_latch_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && !pulse_mode) ##1 !pulse_mode |-> !irq_n_o);
  assert_autoclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr_i && !any_hit) |=> (flags_o == '0));
  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && pulse_mode) ##1 pulse_mode |-> !irq_n_o);
  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PULSE_W));
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PULSE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_strobe,
  output logic [7:0]        rd_data,
  input  logic              tick,
  input  logic [7:0]        t_sec,
  input  logic [7:0]        t_min,
  input  logic [7:0]        t_hour,
  input  logic [7:0]        t_date,
  input  logic [7:0]        t_month,
  input  logic [7:0]        t_dow,
  output logic              irq_n
);
  logic [BYTE_W-1:0]                               ctrl;
  logic [NUM_ALARMS-1:0][NUM_FIELDS-1:0][BYTE_W-1:0] alm;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0]               time_vec;
  logic [NUM_ALARMS-1:0]                           flags;
  logic [NUM_ALARMS-1:0]                           clr_mask;
  logic [NUM_ALARMS-1:0]                           match;
  logic [NUM_ALARMS-1:0]                           hit;
  logic                                            stat_read;
  logic                                            auto_clr;

  assign time_vec  = {t_dow, t_month, t_date, t_hour, t_min, t_sec};
  assign stat_read = rd_strobe && (rd_addr == ADDR_W'(ADDR_STAT));
  assign auto_clr  = stat_read && ctrl[CTL_AUTO];

  alarm_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .flags_i    (flags),
    .ctrl_o     (ctrl),
    .alm_o      (alm),
    .clr_mask_o (clr_mask),
    .rd_data_o  (rd_data)
  );

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_cmp
    alarm_cmp cmp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .enable  (ctrl[CTL_EN0 + a]),
      .alm_i   (alm[a]),
      .time_i  (time_vec),
      .match_o (match[a]),
      .hit_o   (hit[a])
    );
  end

  alarm_irq_gen #(.PULSE_W(PULSE_W)) irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .pulse_mode (ctrl[CTL_MODE]),
    .clr_mask_i (clr_mask),
    .auto_clr_i (auto_clr),
    .flags_o    (flags),
    .irq_n_o    (irq_n)
  );

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> flags[0]);
  assert_match_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> (hit == '0));
endmodule

// File: tb/alarm_irq_unit_tb.sv
module alarm_irq_unit_tb_top;
  localparam int PW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic [7:0] t_sec = '0, t_min = '0, t_hour = '0, t_date = '0, t_month = '0, t_dow = '0;
  logic       irq_n;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  alarm_irq_unit #(.ADDR_W(4), .PULSE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_strobe(rd_strobe), .rd_data(rd_data), .tick(tick),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_date(t_date),
    .t_month(t_month), .t_dow(t_dow), .irq_n(irq_n)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                          logic [7:0] d, logic [7:0] mo, logic [7:0] w);
    t_sec = s; t_min = m; t_hour = h; t_date = d; t_month = mo; t_dow = w;
  endtask

  // tick raised at a falling edge, results checked at the next falling edge
  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle_tick();
    set_time(8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h06);
    do_tick();
  endtask

  task automatic t_reset();
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rd_chk("R1 ctrl", 4'd0, 8'h00);
    rd_chk("R1 status", 4'd1, 8'h00);
    rd_chk("R1 alarm byte", 4'd9, 8'h00);
  endtask

  task automatic t_readback();
    wr(4'd0, 8'hF0);
    rd_chk("R10 ctrl upper bits", 4'd0, 8'h00);
    wr(4'd13, 8'h85);
    rd_chk("R10 alarm1 dow", 4'd13, 8'h85);
    wr(4'd2, 8'hB0);
    wr(4'd3, 8'h95);
    wr(4'd4, 8'h08);
    rd_chk("R10 alarm0 sec", 4'd2, 8'hB0);
    rd_chk("R10 alarm0 min", 4'd3, 8'h95);
    rd_chk("R10 alarm0 hour", 4'd4, 8'h08);
    wr(4'd13, 8'h00);
  endtask

  task automatic t_single();
    wr(4'd0, 8'h01);
    idle_tick();
    set_time(8'h30, 8'h14, 8'h11, 8'h02, 8'h03, 8'h01);
    do_tick();
    chk("R2 minute mismatch irq", {7'd0, irq_n}, 8'h01);
    rd_chk("R2 minute mismatch status", 4'd1, 8'h00);
    set_time(8'h30, 8'h15, 8'h11, 8'h02, 8'h03, 8'h01);
    do_tick();
    chk("R2 R5 match irq low", {7'd0, irq_n}, 8'h00);
    rd_chk("R5 flag0 set", 4'd1, 8'h01);
    wr(4'd1, 8'h02);
    rd_chk("R6 flag0 cleared", 4'd1, 8'h00);
    chk("R5 irq released", {7'd0, irq_n}, 8'h01);
    do_tick();
    rd_chk("R4 repeat match no event", 4'd1, 8'h00);
    set_time(8'h31, 8'h15, 8'h11, 8'h02, 8'h03, 8'h01);
    do_tick();
    set_time(8'h30, 8'h15, 8'h23, 8'h19, 8'h07, 8'h04);
    do_tick();
    rd_chk("R4 R2 new event, unenabled fields ignored", 4'd1, 8'h01);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_shared();
    wr(4'd13, 8'h83);
    wr(4'd0, 8'h03);
    idle_tick();
    set_time(8'h30, 8'h15, 8'h00, 8'h01, 8'h01, 8'h03);
    do_tick();
    rd_chk("R5 both flags", 4'd1, 8'h03);
    wr(4'd1, 8'h03);
    rd_chk("R6 write ones keeps flags", 4'd1, 8'h03);
    wr(4'd1, 8'h02);
    rd_chk("R6 clear flag0 only", 4'd1, 8'h02);
    chk("R5 irq held by flag1", {7'd0, irq_n}, 8'h00);
    wr(4'd1, 8'h00);
    chk("R5 irq high after both clear", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_no_enable();
    wr(4'd13, 8'h03);
    wr(4'd0, 8'h02);
    idle_tick();
    set_time(8'h30, 8'h15, 8'h00, 8'h01, 8'h01, 8'h03);
    do_tick();
    rd_chk("R3 no enabled field", 4'd1, 8'h00);
    chk("R3 irq high", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_disabled();
    wr(4'd0, 8'h00);
    idle_tick();
    set_time(8'h30, 8'h15, 8'h00, 8'h01, 8'h01, 8'h03);
    do_tick();
    rd_chk("R9 disabled alarm no flag", 4'd1, 8'h00);
    chk("R9 irq high", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_autoclr();
    wr(4'd0, 8'h01);
    idle_tick();
    set_time(8'h30, 8'h15, 8'h00, 8'h01, 8'h01, 8'h03);
    do_tick();
    @(negedge clk);
    rd_addr = 4'd1; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    rd_chk("R7 read without auto-clear keeps flag", 4'd1, 8'h01);
    wr(4'd0, 8'h09);
    @(negedge clk);
    rd_addr = 4'd1; rd_strobe = 1'b1;
    #1;
    chk("R7 strobe cycle shows flag", rd_data, 8'h01);
    @(negedge clk);
    rd_strobe = 1'b0;
    rd_chk("R7 auto-clear", 4'd1, 8'h00);
    chk("R7 irq high", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_pulse();
    int n;
    wr(4'd0, 8'h05);
    wr(4'd3, 8'h15);
    idle_tick();
    for (int rep = 0; rep < 2; rep++) begin
      set_time(8'h31, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
      do_tick();
      set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
      do_tick();
      n = 0;
      while (!irq_n && n < 20) begin
        n++;
        @(negedge clk);
      end
      chk("R8 pulse width", 8'(n), 8'(PW));
    end
    rd_chk("R8 flag set in pulsed mode", 4'd1, 8'h01);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_single();
    t_shared();
    t_no_enable();
    t_disabled();
    t_autoclr();
    t_pulse();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule